// File: doc/BRIEF.md
# Reloadable Interval Timer with Timestamp

This block is a register-mapped timer peripheral. It holds a 32-bit timestamp that advances on every clock, two independent down-counting channels, and a status word of sticky event flags. Software moves 32-bit words over a plain register bus. The bus carries a byte address, write data and a write strobe, and read data is returned combinationally for the address currently presented.

Each channel is driven entirely by its control/reload word. Bit 0 of that word starts or stops the channel and bit 1 selects single-shot operation. The remaining upper bits are the reload value, whose two lowest bits always count as zero, so every period is built from a multiple of four. Each time a channel expires it raises a flag and an interrupt line, and both stay up until software writes a one to clear the flag. When the timestamp rolls over it raises a flag of its own.

Top module: `interval_timer_block`

## Requirements
- R1: After reset, both channel counts, both control/reload words and the status word read 0, and both interrupt lines are low.
- R2: Registers sit at fixed byte offsets and decode only address bits [7:2]. The offsets are: timestamp 0x00, channel 0 count 0x04, channel 0 control/reload 0x08, channel 1 count 0x0C, channel 1 control/reload 0x10, status 0x20. The count registers are read-only, and a write to them leaves the count unchanged.
- R3: A control/reload write with bit 0 set to a stopped channel loads the count with the written word with bits [1:0] cleared. The new count is visible one clock later. A control/reload read returns the word exactly as written.
- R4: While running, the count falls by one each clock. A running channel whose count is 0 expires on the next clock edge and sets its status flag. In periodic mode (bit 1 clear) it reloads at the same time, which gives a period of reload+1 clocks.
- R5: In single-shot mode (bit 1 set), expiry clears bit 0 of the stored control/reload word, the count stays at 0, and no later expiry occurs.
- R6: A control/reload write with bit 0 set to a running channel does not disturb the current count. The new reload value is first used at the next expiry.
- R7: A control/reload write with bit 0 clear halts the channel on that clock edge, and the count holds its value.
- R8: Status bit 0 is the channel 0 flag, bit 1 is the channel 1 flag and bit 2 is the timestamp rollover flag. Bits 3 and up read 0. Writing a one to a flag bit clears that flag, and writing a zero leaves it unchanged.
- R9: Output irq_ch[i] follows the channel i status flag and stays high until the flag is cleared.
- R10: The timestamp increments by one each clock and takes a written value directly. Moving from 0xFFFFFFFF to 0 sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one word per clock |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_ch | output | 2 | Per-channel interrupt, bit i for channel i |

## Verification
The hardest situation to reach from the ports is the timestamp rollover, because a free count would need over four billion clocks to get there. The stimulus first writes 0xFFFFFFF0 into the timestamp and then waits sixteen clocks, so the wrap and its status flag arrive on a known edge. Two other cases depend on exact timing: a reload change landing in the middle of a period, and a halt that leaves a nonzero count frozen. For both, the writes are placed on counted edges and the count is read back before and after the expected reload.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_CH   = 2;
  localparam int EN_BIT   = 0;
  localparam int OS_BIT   = 1;
  localparam int CTRL_W   = 2;
  localparam int FLAG_W   = NUM_CH + 1;

  typedef logic [DATA_W-1:0] word_t;

  // word indexes (byte offset / 4)
  localparam int WIDX_STAMP  = 0;
  localparam int WIDX_STATUS = 8;

  function automatic int ch_count_idx(input int ch);
    return 1 + 2 * ch;
  endfunction

  function automatic int ch_reload_idx(input int ch);
    return 2 + 2 * ch;
  endfunction

  // reload value: control bits count as zero
  function automatic word_t reload_of(input word_t w);
    word_t r;
    r = w;
    r[CTRL_W-1:0] = '0;
    return r;
  endfunction

  function automatic word_t next_count(input word_t cur, input word_t word_nx,
                                       input logic running, input logic start,
                                       input logic halt, input logic expire);
    if (start)               return reload_of(word_nx);
    if (!running || halt)    return cur;
    if (expire)              return word_nx[OS_BIT] ? '0 : reload_of(word_nx);
    return cur - word_t'(1);
  endfunction

  function automatic word_t stamp_next(input word_t cur, input logic wr, input word_t wdata);
    return wr ? wdata : cur + word_t'(1);
  endfunction
endpackage

// File: rtl/itb_channel.sv
module itb_channel
  import itb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wdata,
  output word_t count,
  output word_t ctrl,
  output logic  running,
  output logic  start,
  output logic  halt,
  output logic  expire
);
  word_t ctrl_q;
  word_t count_q;
  word_t word_nx;

  assign word_nx = wr_en ? wdata : ctrl_q;
  assign running = ctrl_q[EN_BIT];
  assign start   = wr_en && wdata[EN_BIT] && !ctrl_q[EN_BIT];
  assign halt    = wr_en && !wdata[EN_BIT];
  assign expire  = running && !halt && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      count_q <= '0;
    end else begin
      ctrl_q <= word_nx;
      if (expire && word_nx[OS_BIT]) ctrl_q[EN_BIT] <= 1'b0;
      count_q <= next_count(count_q, word_nx, running, start, halt, expire);
    end
  end

  assign count = count_q;
  assign ctrl  = ctrl_q;
endmodule

// File: rtl/itb_stamp.sv
module itb_stamp
  import itb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wdata,
  output word_t value,
  output logic  wrap
);
  word_t value_q;

  assign wrap = !wr_en && (value_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= stamp_next(value_q, wr_en, wdata);
  end

  assign value = value_q;
endmodule

// File: rtl/itb_pending.sv
module itb_pending #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;

  // a new event wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | set;
  end

  assign pend = pend_q;
endmodule

// File: rtl/interval_timer_block.sv
module interval_timer_block
  import itb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] irq_ch
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  assign widx = reg_addr[ADDR_W-1:2];

  word_t [NUM_CH-1:0] ch_count;
  word_t [NUM_CH-1:0] ch_ctrl;
  logic  [NUM_CH-1:0] ch_wr;
  logic  [NUM_CH-1:0] ch_run;
  logic  [NUM_CH-1:0] ch_start;
  logic  [NUM_CH-1:0] ch_halt;
  logic  [NUM_CH-1:0] ch_expire;
  logic  [NUM_CH-1:0] ch_oneshot;

  word_t stamp_val;
  logic  stamp_wr;
  logic  stamp_wrap;

  logic  status_wr;
  logic  [FLAG_W-1:0] flag_set;
  logic  [FLAG_W-1:0] flag_clr;
  logic  [FLAG_W-1:0] flag_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_wr[c]      = reg_we && (int'(widx) == ch_reload_idx(c));
    assign ch_oneshot[c] = ch_ctrl[c][OS_BIT];
    itb_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ch_wr[c]),
      .wdata   (reg_wdata),
      .count   (ch_count[c]),
      .ctrl    (ch_ctrl[c]),
      .running (ch_run[c]),
      .start   (ch_start[c]),
      .halt    (ch_halt[c]),
      .expire  (ch_expire[c])
    );
  end

  assign stamp_wr = reg_we && (int'(widx) == WIDX_STAMP);

  itb_stamp u_stamp (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (stamp_wr),
    .wdata (reg_wdata),
    .value (stamp_val),
    .wrap  (stamp_wrap)
  );

  assign status_wr = reg_we && (int'(widx) == WIDX_STATUS);
  assign flag_set  = {stamp_wrap, ch_expire};
  assign flag_clr  = status_wr ? reg_wdata[FLAG_W-1:0] : '0;

  itb_pending #(.N(FLAG_W)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .pend  (flag_q)
  );

  assign irq_ch = flag_q[NUM_CH-1:0];

  always_comb begin
    reg_rdata = '0;
    if (int'(widx) == WIDX_STAMP)  reg_rdata = stamp_val;
    if (int'(widx) == WIDX_STATUS) reg_rdata = {{(DATA_W-FLAG_W){1'b0}}, flag_q};
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(widx) == ch_count_idx(c))  reg_rdata = ch_count[c];
      if (int'(widx) == ch_reload_idx(c)) reg_rdata = ch_ctrl[c];
    end
  end
endmodule

// File: rtl/itb_checker.sv
module itb_checker #(
  parameter int N = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N-1:0][31:0] count,
  input logic [N-1:0]       wr,
  input logic [N-1:0]       running,
  input logic [N-1:0]       start,
  input logic [N-1:0]       halt,
  input logic [N-1:0]       expire,
  input logic [N-1:0]       oneshot,
  input logic [31:0]        stamp,
  input logic               stamp_wr,
  input logic               stamp_wrap,
  input logic [N:0]         pend,
  input logic [N:0]         clr
);
  for (genvar c = 0; c < N; c++) begin : g_chk
    p_expire_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      expire[c] |=> pend[c]);
    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire[c] && oneshot[c] && !wr[c] |=> !running[c]);
    p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt[c] || (!running[c] && !start[c])) |=> $stable(count[c]));
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend[c] && !clr[c] |=> pend[c]);
    p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[c]) |-> $past(expire[c]));
  end

  p_stamp_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_wr |=> stamp == $past(stamp) + 32'd1);
  p_wrap_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_wrap |=> pend[N]);
endmodule

bind interval_timer_block itb_checker #(.N(itb_pkg::NUM_CH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .count      (ch_count),
  .wr         (ch_wr),
  .running    (ch_run),
  .start      (ch_start),
  .halt       (ch_halt),
  .expire     (ch_expire),
  .oneshot    (ch_oneshot),
  .stamp      (stamp_val),
  .stamp_wr   (stamp_wr),
  .stamp_wrap (stamp_wrap),
  .pend       (flag_q),
  .clr        (flag_clr)
);

// File: tb/interval_timer_block_tb_top.sv
`timescale 1ns/10ps
module interval_timer_block_tb_top;
  localparam logic [7:0] A_STAMP = 8'h00;
  localparam logic [7:0] A_C0CNT = 8'h04;
  localparam logic [7:0] A_C0RLD = 8'h08;
  localparam logic [7:0] A_C1CNT = 8'h0C;
  localparam logic [7:0] A_C1RLD = 8'h10;
  localparam logic [7:0] A_STAT  = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_ch;

  always #2.5 clk = ~clk;

  interval_timer_block dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_ch(irq_ch)
  );

  typedef struct {
    logic        is_irq;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  sb_kick;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // monitor: pops expectations and compares against outputs
  initial begin
    forever begin
      @(sb_kick);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = sb_q.pop_front();
        got = it.is_irq ? {30'd0, irq_ch} : reg_rdata;
        n_chk++;
        if ((got & it.mask) !== (it.exp & it.mask)) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, got & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] m,
                            input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.is_irq = 1'b0; it.mask = m; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    #0.1;
    ->sb_kick;
    #0.1;
  endtask

  task automatic expect_irq(input logic [1:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.mask = 32'h3; it.exp = {30'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    #0.1;
    ->sb_kick;
    #0.1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    expect_reg(A_C0CNT, ALL, 0, "R1 ch0 count");
    expect_reg(A_C0RLD, ALL, 0, "R1 ch0 ctrl");
    expect_reg(A_C1CNT, ALL, 0, "R1 ch1 count");
    expect_reg(A_C1RLD, ALL, 0, "R1 ch1 ctrl");
    expect_reg(A_STAT,  ALL, 0, "R1 status");
    expect_irq(2'b00, "R1 irq");

    // R3/R4 periodic reload 8
    wr(A_C0RLD, 32'h9);
    expect_reg(A_C0CNT, ALL, 8, "R3 load count");
    idle(8);
    expect_reg(A_C0CNT, ALL, 0, "R4 count at zero");
    expect_reg(A_STAT, 32'h1, 0, "R4 no flag yet");
    idle(1);
    expect_reg(A_STAT, 32'h1, 1, "R4 expiry flag");
    expect_reg(A_C0CNT, ALL, 8, "R4 periodic reload");
    expect_irq(2'b01, "R9 irq follows flag");

    // R8 write-one clear, then second period
    wr(A_STAT, 32'h1);
    expect_reg(A_STAT, 32'h1, 0, "R8 clear by one");
    expect_irq(2'b00, "R9 irq cleared");
    idle(7);
    expect_reg(A_STAT, 32'h1, 0, "R4 second period not yet");
    idle(1);
    expect_reg(A_STAT, 32'h1, 1, "R4 second expiry");
    wr(A_STAT, 32'h0);
    expect_reg(A_STAT, 32'h1, 1, "R8 zero write keeps flag");
    expect_irq(2'b01, "R9 irq persists");

    // R7 halt at count 7
    wr(A_C0RLD, 32'h0);
    idle(5);
    expect_reg(A_C0CNT, ALL, 7, "R7 count held");
    expect_reg(A_C0RLD, ALL, 0, "R7 ctrl reads zero");
    wr(A_STAT, 32'h1);
    expect_reg(A_STAT, ALL, 0, "R8 all clear");

    // R3 low bits masked, R5 single-shot
    wr(A_C0RLD, 32'hF);
    expect_reg(A_C0CNT, ALL, 12, "R3 low bits masked");
    expect_reg(A_C0RLD, ALL, 32'hF, "R3 ctrl readback");
    idle(12);
    expect_reg(A_C0CNT, ALL, 0, "R5 count reached zero");
    idle(1);
    expect_reg(A_STAT, 32'h1, 1, "R5 single-shot flag");
    expect_reg(A_C0RLD, ALL, 32'hE, "R5 enable cleared");
    idle(10);
    expect_reg(A_C0CNT, ALL, 0, "R5 count stays zero");
    wr(A_STAT, 32'h1);
    idle(20);
    expect_reg(A_STAT, 32'h1, 0, "R5 no second expiry");

    // R6 reload change mid-period on channel 1
    wr(A_C1RLD, 32'h11);
    wr(A_C1RLD, 32'h41);
    expect_reg(A_C1CNT, ALL, 15, "R6 count undisturbed");
    idle(15);
    expect_reg(A_C1CNT, ALL, 0, "R6 count at zero");
    idle(1);
    expect_reg(A_C1CNT, ALL, 64, "R6 new reload used");
    expect_reg(A_STAT, 32'h3, 2, "R8 channel 1 bit position");
    expect_irq(2'b10, "R9 channel 1 irq");

    // R2 count registers read-only
    wr(A_C1CNT, 32'h1234);
    expect_reg(A_C1CNT, ALL, 63, "R2 count write ignored");
    wr(A_C0CNT, 32'h55);
    expect_reg(A_C0CNT, ALL, 0, "R2 stopped count write ignored");
    wr(A_C1RLD, 32'h0);
    wr(A_STAT, 32'h7);
    expect_reg(A_STAT, ALL, 0, "R8 clear all flags");

    // R10 timestamp write and rollover
    wr(A_STAMP, 32'hFFFF_FFF0);
    expect_reg(A_STAMP, ALL, 32'hFFFF_FFF0, "R10 stamp written");
    idle(15);
    expect_reg(A_STAMP, ALL, 32'hFFFF_FFFF, "R10 stamp top");
    expect_reg(A_STAT, 32'h4, 0, "R10 no wrap yet");
    idle(1);
    expect_reg(A_STAMP, ALL, 0, "R10 stamp wrapped");
    expect_reg(A_STAT, ALL, 32'h4, "R10 R8 wrap flag only");
    expect_irq(2'b00, "R9 wrap not on channel irq");
    wr(A_STAT, 32'h4);
    expect_reg(A_STAT, ALL, 0, "R8 wrap flag cleared");
    wr(A_STAMP, 32'h0);
    idle(5);
    expect_reg(A_STAMP, ALL, 5, "R10 stamp counts from zero");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule